// File: doc/BRIEF.md
# Paired Serial Port Loopback Router

This block sits between a bank of serial port cores and their pads. Each port carries four signals: a bit clock, a frame sync and two data lanes, A and B. In normal operation every signal passes straight between a core and its own pads with no register in the path. Ports are grouped into fixed neighbouring pairs: port 2p and port 2p+1. When both ports of a pair are set to loopback, the receiving core takes all four inputs from its partner's outputs instead of from the pins. This lets software test a transmit/receive path fully on chip.

A port with its loopback enable set stops driving its pads and ignores everything that arrives on them. This avoids contention with the internal transfer. Each port has a mode-control word, written through a small synchronous write port addressed by port index. Only the loopback enable bit of that word is kept. A per-pair error flag reports loopback setups that cannot work:
- only one port of the pair is enabled,
- the two ports have the same direction,
- the transmitter does not generate its own clock and frame sync,
- the receiver tries to generate its own clock or frame sync.

Top module: `slb_router`

## Requirements
- R1: After reset, every port has loopback disabled: all ports pass through and every `pair_err` bit is 0.
- R2: A write (`cfg_we`=1 at a rising clock edge) copies bit 12 of the 16-bit `cfg_wdata` into the loopback enable of port `cfg_idx`. The change is visible from that edge onward. All other bits of `cfg_wdata` have no effect, and no other port changes.
- R3: For a port with loopback disabled, in the same cycle:
  - `core_*_i` equals `pad_*_i`,
  - `pad_*_o` equals `core_*_o`,
  - `pad_*_oe` equals `core_*_oe`,
  
  for clock, frame sync, lane A and lane B. `pad_*_o` always equals `core_*_o`, whatever the port's mode.
- R4: Ports are paired by index as 2p with 2p+1 (0-1, 2-3, 4-5, 6-7), and `pair_err[p]` belongs to that pair.
- R5: When both ports of a pair have loopback enabled, each port's four core inputs equal its partner's four core outputs in the same cycle.
- R6: A port with loopback enabled holds all four pad output enables at 0.
- R7: A port with loopback enabled ignores its pad inputs. If its partner is not enabled, all four core inputs of that port read 0.
- R8: `pair_err[p]` is 1 when exactly one port of the pair has loopback enabled.
- R9: `pair_err[p]` is 1 when both ports are enabled and `role_tx` (1 = transmit, 0 = receive) is equal for the two ports.
- R10: When both ports are enabled with opposite roles, `pair_err[p]` is 1 exactly when either of these holds:
  - the transmitter lacks `int_clk` or `int_fs`,
  - the receiver has `int_clk` or `int_fs` set.
- R11: `pair_err[p]` is 0 whenever neither port of the pair has loopback enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Mode-control write strobe |
| cfg_idx | input | 3 | Port index of the write |
| cfg_wdata | input | 16 | Mode-control word; bit 12 is the loopback enable |
| role_tx | input | 8 | Per-port direction, 1 = transmitter |
| int_clk | input | 8 | Per-port: core generates its own bit clock |
| int_fs | input | 8 | Per-port: core generates its own frame sync |
| core_clk_o | input | 8 | Clock from each core |
| core_clk_oe | input | 8 | Clock drive enable from each core |
| core_fs_o | input | 8 | Frame sync from each core |
| core_fs_oe | input | 8 | Frame sync drive enable from each core |
| core_da_o | input | 8 | Lane A data from each core |
| core_da_oe | input | 8 | Lane A drive enable from each core |
| core_db_o | input | 8 | Lane B data from each core |
| core_db_oe | input | 8 | Lane B drive enable from each core |
| pad_clk_i | input | 8 | Clock sampled at each pad |
| pad_fs_i | input | 8 | Frame sync sampled at each pad |
| pad_da_i | input | 8 | Lane A sampled at each pad |
| pad_db_i | input | 8 | Lane B sampled at each pad |
| core_clk_i | output | 8 | Clock delivered to each core |
| core_fs_i | output | 8 | Frame sync delivered to each core |
| core_da_i | output | 8 | Lane A delivered to each core |
| core_db_i | output | 8 | Lane B delivered to each core |
| pad_clk_o | output | 8 | Clock driven to each pad |
| pad_clk_oe | output | 8 | Clock pad enable |
| pad_fs_o | output | 8 | Frame sync driven to each pad |
| pad_fs_oe | output | 8 | Frame sync pad enable |
| pad_da_o | output | 8 | Lane A driven to each pad |
| pad_da_oe | output | 8 | Lane A pad enable |
| pad_db_o | output | 8 | Lane B driven to each pad |
| pad_db_oe | output | 8 | Lane B pad enable |
| pair_err | output | 4 | Per-pair loopback configuration error |

## Verification
Routing, pad enables and the error flags are purely combinational, so they are due in the same cycle as the input change. A loopback enable write takes effect at the rising edge that samples `cfg_we`. The bench therefore changes all inputs 1 ns after a rising edge and compares every output at the following falling edge. By that time any write issued in the preceding cycle has already landed. Expected values come from a bench-side copy of the eight enable bits, which is updated at the write edge.

// File: rtl/slb_pkg.sv
package slb_pkg;

    // One port's four serial signals, kept together so routing moves them as a unit.
    typedef struct packed {
        logic clk;
        logic fs;
        logic da;
        logic db;
    } slb_sig_t;

endpackage

// File: rtl/slb_ctrl_regs.sv
module slb_ctrl_regs #(
    parameter int N_PORTS  = 8,
    parameter int CTRL_W   = 16,
    parameter int LPBK_BIT = 12,
    parameter int IDX_W    = $clog2(N_PORTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [CTRL_W-1:0]  cfg_wdata,
    output logic [N_PORTS-1:0] lpbk_en
);

    typedef struct packed {
        logic [N_PORTS-1:0] lb;
    } regs_t;

    regs_t regs_d, regs_q;

    // Only the loopback bit of the control word is kept; the rest is dropped.
    logic unused_wbits;
    assign unused_wbits = ^{cfg_wdata[CTRL_W-1:LPBK_BIT+1], cfg_wdata[LPBK_BIT-1:0]};

    always_comb begin
        regs_d = regs_q;
        if (cfg_we && (int'(cfg_idx) < N_PORTS)) begin
            regs_d.lb[cfg_idx] = cfg_wdata[LPBK_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign lpbk_en = regs_q.lb;

    for (genvar g = 0; g < N_PORTS; g++) begin : g_chk
        // R2: an addressed write lands with the sampled enable bit
        p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && (int'(cfg_idx) == g)) |=> (lpbk_en[g] == $past(cfg_wdata[LPBK_BIT])));
        // R2: a port not addressed keeps its enable
        p_others_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !(cfg_we && (int'(cfg_idx) == g)) |=> $stable(lpbk_en[g]));
    end

endmodule

// File: rtl/slb_pair_route.sv
module slb_pair_route
    import slb_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     lb,
    input  logic [1:0]     role_tx,
    input  logic [1:0]     int_clk,
    input  logic [1:0]     int_fs,
    input  slb_sig_t [1:0] core_o,
    input  slb_sig_t [1:0] core_oe,
    input  slb_sig_t [1:0] pad_i,
    output slb_sig_t [1:0] core_i,
    output slb_sig_t [1:0] pad_o,
    output slb_sig_t [1:0] pad_oe,
    output logic           err
);

    logic active;
    logic any_lb;
    logic roles_eq;
    logic tx_sel;
    logic rx_sel;
    logic clk_bad;

    assign active = lb[0] & lb[1];
    assign any_lb = lb[0] | lb[1];

    for (genvar k = 0; k < 2; k++) begin : g_side
        always_comb begin
            if (active) begin
                core_i[k] = core_o[1-k];
            end else if (lb[k]) begin
                core_i[k] = '0;
            end else begin
                core_i[k] = pad_i[k];
            end
            pad_o[k]  = core_o[k];
            pad_oe[k] = lb[k] ? '0 : core_oe[k];
        end

        // R6: an enabled port never drives its pads
        p_pins_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
            lb[k] |-> (pad_oe[k] == '0));
        // R5: active pair feeds each core from its partner
        p_partner_feed_r5: assert property (@(posedge clk) disable iff (!rst_n)
            active |-> (core_i[k] == core_o[1-k]));
        // R7: a lone enabled port sees nothing
        p_lone_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (lb[k] && !lb[1-k]) |-> (core_i[k] == '0));
        // R3: disabled port is a wire to its pads
        p_passthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !lb[k] |-> ((core_i[k] == pad_i[k]) && (pad_oe[k] == core_oe[k])));
    end

    // Direction and clocking sanity of the pair.
    always_comb begin
        roles_eq = (role_tx[0] == role_tx[1]);
        tx_sel   = role_tx[1];
        rx_sel   = ~role_tx[1];
        clk_bad  = ~(int_clk[tx_sel] & int_fs[tx_sel]) | int_clk[rx_sel] | int_fs[rx_sel];
        err      = any_lb & (~active | roles_eq | clk_bad);
    end

    // R8: half-enabled pair always flags
    p_half_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lb[0] != lb[1]) |-> err);
    // R9: same-direction pair in loopback flags
    p_same_role_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && (role_tx[0] == role_tx[1])) |-> err);
    // R11: idle pair never flags
    p_idle_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (lb == 2'b00) |-> !err);

endmodule

// File: rtl/slb_router.sv
module slb_router
    import slb_pkg::*;
#(
    parameter int N_PORTS  = 8,
    parameter int CTRL_W   = 16,
    parameter int LPBK_BIT = 12,
    localparam int IDX_W   = $clog2(N_PORTS),
    localparam int N_PAIRS = N_PORTS / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [CTRL_W-1:0]  cfg_wdata,
    input  logic [N_PORTS-1:0] role_tx,
    input  logic [N_PORTS-1:0] int_clk,
    input  logic [N_PORTS-1:0] int_fs,
    input  logic [N_PORTS-1:0] core_clk_o,
    input  logic [N_PORTS-1:0] core_clk_oe,
    input  logic [N_PORTS-1:0] core_fs_o,
    input  logic [N_PORTS-1:0] core_fs_oe,
    input  logic [N_PORTS-1:0] core_da_o,
    input  logic [N_PORTS-1:0] core_da_oe,
    input  logic [N_PORTS-1:0] core_db_o,
    input  logic [N_PORTS-1:0] core_db_oe,
    input  logic [N_PORTS-1:0] pad_clk_i,
    input  logic [N_PORTS-1:0] pad_fs_i,
    input  logic [N_PORTS-1:0] pad_da_i,
    input  logic [N_PORTS-1:0] pad_db_i,
    output logic [N_PORTS-1:0] core_clk_i,
    output logic [N_PORTS-1:0] core_fs_i,
    output logic [N_PORTS-1:0] core_da_i,
    output logic [N_PORTS-1:0] core_db_i,
    output logic [N_PORTS-1:0] pad_clk_o,
    output logic [N_PORTS-1:0] pad_clk_oe,
    output logic [N_PORTS-1:0] pad_fs_o,
    output logic [N_PORTS-1:0] pad_fs_oe,
    output logic [N_PORTS-1:0] pad_da_o,
    output logic [N_PORTS-1:0] pad_da_oe,
    output logic [N_PORTS-1:0] pad_db_o,
    output logic [N_PORTS-1:0] pad_db_oe,
    output logic [N_PAIRS-1:0] pair_err
);

    logic     [N_PORTS-1:0] lpbk_en;
    slb_sig_t [N_PORTS-1:0] core_o_s;
    slb_sig_t [N_PORTS-1:0] core_oe_s;
    slb_sig_t [N_PORTS-1:0] pad_i_s;
    slb_sig_t [N_PORTS-1:0] core_i_s;
    slb_sig_t [N_PORTS-1:0] pad_o_s;
    slb_sig_t [N_PORTS-1:0] pad_oe_s;

    slb_ctrl_regs #(
        .N_PORTS  (N_PORTS),
        .CTRL_W   (CTRL_W),
        .LPBK_BIT (LPBK_BIT),
        .IDX_W    (IDX_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .lpbk_en   (lpbk_en)
    );

    for (genvar i = 0; i < N_PORTS; i++) begin : g_port
        assign core_o_s[i]  = '{clk: core_clk_o[i],  fs: core_fs_o[i],  da: core_da_o[i],  db: core_db_o[i]};
        assign core_oe_s[i] = '{clk: core_clk_oe[i], fs: core_fs_oe[i], da: core_da_oe[i], db: core_db_oe[i]};
        assign pad_i_s[i]   = '{clk: pad_clk_i[i],   fs: pad_fs_i[i],   da: pad_da_i[i],   db: pad_db_i[i]};

        assign core_clk_i[i] = core_i_s[i].clk;
        assign core_fs_i[i]  = core_i_s[i].fs;
        assign core_da_i[i]  = core_i_s[i].da;
        assign core_db_i[i]  = core_i_s[i].db;
        assign pad_clk_o[i]  = pad_o_s[i].clk;
        assign pad_fs_o[i]   = pad_o_s[i].fs;
        assign pad_da_o[i]   = pad_o_s[i].da;
        assign pad_db_o[i]   = pad_o_s[i].db;
        assign pad_clk_oe[i] = pad_oe_s[i].clk;
        assign pad_fs_oe[i]  = pad_oe_s[i].fs;
        assign pad_da_oe[i]  = pad_oe_s[i].da;
        assign pad_db_oe[i]  = pad_oe_s[i].db;
    end

    // R4: fixed neighbour pairing, ports 2p and 2p+1
    for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
        slb_pair_route u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .lb      (lpbk_en[2*p+1:2*p]),
            .role_tx (role_tx[2*p+1:2*p]),
            .int_clk (int_clk[2*p+1:2*p]),
            .int_fs  (int_fs[2*p+1:2*p]),
            .core_o  (core_o_s[2*p+1:2*p]),
            .core_oe (core_oe_s[2*p+1:2*p]),
            .pad_i   (pad_i_s[2*p+1:2*p]),
            .core_i  (core_i_s[2*p+1:2*p]),
            .pad_o   (pad_o_s[2*p+1:2*p]),
            .pad_oe  (pad_oe_s[2*p+1:2*p]),
            .err     (pair_err[p])
        );
    end

endmodule

// File: tb/tb_slb_router.sv
module tb_slb_router;

    localparam int N = 8;
    localparam int P = N / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_idx = '0;
    logic [15:0] cfg_wdata = '0;
    logic [N-1:0] role_tx = '0, int_clk = '0, int_fs = '0;
    logic [N-1:0] core_clk_o = '0, core_clk_oe = '0, core_fs_o = '0, core_fs_oe = '0;
    logic [N-1:0] core_da_o = '0, core_da_oe = '0, core_db_o = '0, core_db_oe = '0;
    logic [N-1:0] pad_clk_i = '0, pad_fs_i = '0, pad_da_i = '0, pad_db_i = '0;
    logic [N-1:0] core_clk_i, core_fs_i, core_da_i, core_db_i;
    logic [N-1:0] pad_clk_o, pad_clk_oe, pad_fs_o, pad_fs_oe;
    logic [N-1:0] pad_da_o, pad_da_oe, pad_db_o, pad_db_oe;
    logic [P-1:0] pair_err;

    logic [N-1:0] lb_m = '0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    slb_router dut (.*);

    task automatic chk(input string tag, input int item, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s item %0d: actual %h expected %h", tag, item, act, exp);
        end
    endtask

    function automatic logic exp_err(input int p);
        logic a, b, tx, rx;
        a = lb_m[2*p];
        b = lb_m[2*p+1];
        if (!(a | b)) return 1'b0;
        if (a ^ b) return 1'b1;
        if (role_tx[2*p] == role_tx[2*p+1]) return 1'b1;
        tx = role_tx[2*p+1];
        rx = ~tx;
        return ~(int_clk[2*p+tx] & int_fs[2*p+tx]) | int_clk[2*p+rx] | int_fs[2*p+rx];
    endfunction

    function automatic string err_tag(input int p);
        logic a, b;
        a = lb_m[2*p];
        b = lb_m[2*p+1];
        if (!(a | b)) return "R11";
        if (a ^ b) return "R8";
        if (role_tx[2*p] == role_tx[2*p+1]) return "R9";
        return "R10";
    endfunction

    task automatic check_all();
        for (int i = 0; i < N; i++) begin
            int pt;
            logic both;
            logic [3:0] e4, a4, oe4, co4, po4;
            pt   = i ^ 1;
            both = lb_m[i] & lb_m[pt];
            a4   = {core_clk_i[i], core_fs_i[i], core_da_i[i], core_db_i[i]};
            if (both) e4 = {core_clk_o[pt], core_fs_o[pt], core_da_o[pt], core_db_o[pt]};
            else if (lb_m[i]) e4 = 4'b0000;
            else e4 = {pad_clk_i[i], pad_fs_i[i], pad_da_i[i], pad_db_i[i]};
            chk(both ? "R4,R5 core inputs" : (lb_m[i] ? "R7 core inputs" : "R3 core inputs"), i, 32'(a4), 32'(e4));
            oe4 = {pad_clk_oe[i], pad_fs_oe[i], pad_da_oe[i], pad_db_oe[i]};
            co4 = {core_clk_oe[i], core_fs_oe[i], core_da_oe[i], core_db_oe[i]};
            chk(lb_m[i] ? "R6 pad enables" : "R3 pad enables", i, 32'(oe4), lb_m[i] ? 32'(0) : 32'(co4));
            po4 = {pad_clk_o[i], pad_fs_o[i], pad_da_o[i], pad_db_o[i]};
            chk("R3 pad outputs", i, 32'(po4),
                32'({core_clk_o[i], core_fs_o[i], core_da_o[i], core_db_o[i]}));
        end
        for (int p = 0; p < P; p++) begin
            chk({err_tag(p), " pair_err"}, p, 32'(pair_err[p]), 32'(exp_err(p)));
        end
    endtask

    task automatic rand_data();
        core_clk_o = N'($urandom); core_clk_oe = N'($urandom);
        core_fs_o  = N'($urandom); core_fs_oe  = N'($urandom);
        core_da_o  = N'($urandom); core_da_oe  = N'($urandom);
        core_db_o  = N'($urandom); core_db_oe  = N'($urandom);
        pad_clk_i  = N'($urandom); pad_fs_i    = N'($urandom);
        pad_da_i   = N'($urandom); pad_db_i    = N'($urandom);
    endtask

    // Drive 1 ns after an edge; the write lands at the next edge.
    task automatic write_port(input int idx, input logic [15:0] data);
        cfg_we    = 1'b1;
        cfg_idx   = 3'(idx);
        cfg_wdata = data;
        @(posedge clk);
        lb_m[idx] = data[12];
        #1;
        cfg_we    = 1'b0;
        cfg_wdata = 16'(~data);
    endtask

    task automatic settle_check();
        @(negedge clk);
        check_all();
        @(posedge clk);
        #1;
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        rand_data();
        repeat (3) @(posedge clk);
        #1;
        // R1: during reset everything passes through
        @(negedge clk);
        chk("R1 pair_err in reset", 0, 32'(pair_err), 32'(0));
        chk("R1 clock passthrough", 0, 32'(core_clk_i), 32'(pad_clk_i));
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        rand_data();
        settle_check();

        // R8/R7: only port 0 enabled
        write_port(0, 16'h1000);
        rand_data();
        settle_check();

        // R10: valid pair 0, port 0 transmits with internal clock and sync
        role_tx[1:0] = 2'b01; int_clk[1:0] = 2'b01; int_fs[1:0] = 2'b01;
        write_port(1, 16'h1234);
        rand_data();
        settle_check();
        chk("R10 valid pair clean", 0, 32'(pair_err[0]), 32'(0));

        // R10: reversed direction also valid
        role_tx[1:0] = 2'b10; int_clk[1:0] = 2'b10; int_fs[1:0] = 2'b10;
        settle_check();
        chk("R10 reversed pair clean", 0, 32'(pair_err[0]), 32'(0));

        // R9: both transmitters
        role_tx[1:0] = 2'b11;
        settle_check();

        // R10: transmitter lacks internal frame sync
        role_tx[1:0] = 2'b10; int_fs[1:0] = 2'b00;
        settle_check();

        // R10: receiver claims internal clock
        int_fs[1:0] = 2'b10; int_clk[1:0] = 2'b11;
        settle_check();

        // R2: all bits except 12 set; port 0 leaves loopback
        write_port(0, 16'hEFFF);
        rand_data();
        settle_check();
        chk("R2 other bits ignored", 0, 32'(pad_clk_oe[0]), 32'(core_clk_oe[0]));

        // Random phase
        for (int it = 0; it < 400; it++) begin
            role_tx = N'($urandom); int_clk = N'($urandom); int_fs = N'($urandom);
            if ($urandom_range(2, 0) == 0) begin
                write_port(int'($urandom_range(N-1, 0)), 16'($urandom));
            end
            rand_data();
            settle_check();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule